// File: doc/BRIEF.md
# Lockable Flash Controller Register File

This block is the 32-bit software-visible register file of a serial flash controller. A host reaches it through a simple word-aligned read/write port: writes take effect at the clock edge, and read data and an access-error flag appear one cycle after the access. The stored configuration words are driven straight out to the rest of the controller. These include the read and write setup, the command setup, the opcode, the address and four outgoing data words. A separate transaction engine consumes these words. That engine is not part of this block.

The block protects its configuration in two ways. Each of the three setup words freezes itself once its top bit is written to 1. A second bit in the command setup freezes only a few fields of that word. The control/status word has several active parts:

- a ready flag that software clears by writing 1 to it,
- an execute bit that launches the engine and stays set until the engine reports completion,
- a software chip-select bit that drives one of the active-low chip-select lines.

The engine loads four incoming data words through a dedicated port. Software can only read those words. An interrupt output is raised while the ready flag and its enable are both set.

Execution is tracked by a three-state machine:

- IDLE goes to LAUNCH when software writes 1 to the execute bit.
- LAUNCH always goes to BUSY on the next cycle, and the engine start pulse is high during LAUNCH.
- BUSY goes back to IDLE in the cycle the engine reports done.

Chip selects are tracked by a two-state machine:

- OPEN goes to HELD (or HELD moves to a new line) when the software chip-select bit falls.
- HELD goes to OPEN when that bit rises with no execution pending, or when it falls with a device number outside the fitted lines.

Top module: `flash_ctl_regs`

## Requirements
- R1: Word offsets map as: 0x00 read setup, 0x04 write setup, 0x08 command setup, 0x0C control/status, 0x10 opcode, 0x14 address, 0x18 protection setup, 0x20–0x2C outgoing data 0–3, 0x30–0x3C incoming data 0–3, 0x40–0x64 protection commands 0–9, 0x78 global setup. Plain words read back what was last written. Read data and `reg_err` are valid in the cycle after the access.
- R2: After reset the words read as follows: command setup 0x00000400, control/status 0x00010000, opcode 0x0000000B, protection setup 0x00000400, global setup 0x0000000B, everything else 0. All `cs_n` lines are high and `irq` is 0.
- R3: When bit 31 of the read setup, write setup or command setup word is 1, a write to that word leaves it unchanged and raises `reg_err`.
- R4: When bit 30 of the command setup word is 1, a write to it keeps the old values of bits 10, 1 and 0 (mask 0x00000403). The other bits, bit 30 included, take the written value.
- R5: In control/status, bit 24 is the ready flag. Writing 1 there clears it, and writing 0 leaves it unchanged. Engine completion sets it, and completion wins over a clearing write in the same cycle.
- R6: Bit 0 of control/status is the execute bit. Writing 1 while it is clear raises `eng_start` for exactly the one cycle after the write. The bit then reads 1 until `eng_done` is seen at least one cycle after that start. Writing 0 to it does not clear it, and writing 1 while it is set does not start again.
- R7: When control/status bit 16 (software chip select) is written from 1 to 0, the line numbered by the written bits 9:8 is driven low, replacing any other. If that number is not below NUM_CS, every line goes high. At most one line is low at any time.
- R8: When bit 16 is written from 0 to 1, all lines go high unless the execute bit is already set or is being written as 1 in the same write. In that case the held line stays low.
- R9: Incoming data words are loaded only by the engine port. A software write to them leaves them unchanged and raises `reg_err`.
- R10: A read of an unmapped or misaligned offset returns 0 with `reg_err`. A write to one raises `reg_err` and changes nothing.
- R11: `irq` is 1 exactly while the ready flag and control/status bit 25 (interrupt enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| reg_err | output | 1 | Access flagged, one cycle after the access |
| eng_start | output | 1 | One-cycle transaction launch pulse |
| eng_done | input | 1 | Engine completion strobe |
| eng_din_we | input | 1 | Engine load of an incoming data word |
| eng_din_idx | input | 2 | Incoming data word index |
| eng_din_data | input | 32 | Incoming data value |
| cfg_read | output | 32 | Read setup word |
| cfg_write | output | 32 | Write setup word |
| cfg_cmd | output | 32 | Command setup word |
| cmd_word | output | 32 | Opcode word |
| addr_word | output | 32 | Address word |
| dout_words | output | 128 | Outgoing data words, word 0 in bits 31:0 |
| cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Ready interrupt |

## Verification
The hardest state to reach is a rising software chip-select while execution is pending, either from an earlier start or from the same write that launches one. It needs a held line, a launch and a completion in a precise order. Directed sequences build it both ways and then confirm that the line stays low. After that, a fall with an out-of-range device number is driven on a bench instance that has three lines. Between these, seeded random writes and engine loads over the whole offset space are compared with a bench model of each word.

// File: rtl/flc_pkg.sv
package flc_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 4;
    localparam int NUM_DATA = 4;
    localparam int NUM_PCMD = 10;
    localparam int DEV_W    = 2;

    // word indices (offset / 4)
    localparam int W_RDCFG  = 0;
    localparam int W_WRCFG  = 1;
    localparam int W_CMDCFG = 2;
    localparam int W_CTRL   = 3;
    localparam int W_CMD    = 4;
    localparam int W_ADDR   = 5;
    localparam int W_PCFG   = 6;
    localparam int W_DOUT   = 8;
    localparam int W_DIN    = 12;
    localparam int W_PCMD   = 16;
    localparam int W_GCFG   = 30;

    localparam int B_LOCK  = 31;
    localparam int B_FLOCK = 30;
    localparam int B_IE    = 25;
    localparam int B_RDY   = 24;
    localparam int B_SWCS  = 16;
    localparam int B_DEV   = 8;
    localparam int B_EXEC  = 0;

    localparam logic [DATA_W-1:0] FIELD_LOCK_MASK = 32'h0000_0403;
    localparam logic [DATA_W-1:0] CTRL_LIVE_MASK  = 32'h0100_0001;

    localparam logic [DATA_W-1:0] RST_CMDCFG = 32'h0000_0400;
    localparam logic [DATA_W-1:0] RST_CTRL   = 32'h0001_0000;
    localparam logic [DATA_W-1:0] RST_CMD    = 32'h0000_000B;
    localparam logic [DATA_W-1:0] RST_PCFG   = 32'h0000_0400;
    localparam logic [DATA_W-1:0] RST_GCFG   = 32'h0000_000B;

    typedef enum logic [3:0] {
        RK_NONE, RK_RDCFG, RK_WRCFG, RK_CMDCFG, RK_CTRL, RK_CMD,
        RK_ADDR, RK_PCFG, RK_DOUT, RK_DIN, RK_PCMD, RK_GCFG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef enum logic [1:0] {EX_IDLE, EX_LAUNCH, EX_BUSY} exec_state_e;
    typedef enum logic {CS_OPEN, CS_HELD} cs_state_e;
endpackage

// File: rtl/flc_decode.sv
module flc_decode
    import flc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    int word;

    always_comb begin
        sel  = '0;
        word = 0;
        word[ADDR_W-3:0] = addr[ADDR_W-1:2];
        if (addr[1:0] == 2'b00) begin
            if (word == W_RDCFG)       sel.kind = RK_RDCFG;
            else if (word == W_WRCFG)  sel.kind = RK_WRCFG;
            else if (word == W_CMDCFG) sel.kind = RK_CMDCFG;
            else if (word == W_CTRL)   sel.kind = RK_CTRL;
            else if (word == W_CMD)    sel.kind = RK_CMD;
            else if (word == W_ADDR)   sel.kind = RK_ADDR;
            else if (word == W_PCFG)   sel.kind = RK_PCFG;
            else if (word == W_GCFG)   sel.kind = RK_GCFG;
            else if (word >= W_DOUT && word < W_DOUT + NUM_DATA) begin
                sel.kind = RK_DOUT;
                sel.idx  = IDX_W'(word - W_DOUT);
            end else if (word >= W_DIN && word < W_DIN + NUM_DATA) begin
                sel.kind = RK_DIN;
                sel.idx  = IDX_W'(word - W_DIN);
            end else if (word >= W_PCMD && word < W_PCMD + NUM_PCMD) begin
                sel.kind = RK_PCMD;
                sel.idx  = IDX_W'(word - W_PCMD);
            end
        end
    end
endmodule

// File: rtl/flc_exec_fsm.sv
module flc_exec_fsm
    import flc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic done,
    output logic start,
    output logic busy,
    output logic finish
);
    exec_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EX_IDLE:   if (go) state_d = EX_LAUNCH;
            EX_LAUNCH: state_d = EX_BUSY;
            EX_BUSY:   if (done) state_d = EX_IDLE;
            default:   state_d = EX_IDLE;
        endcase
    end

    always_comb begin
        start  = (state_q == EX_LAUNCH);
        busy   = (state_q != EX_IDLE);
        finish = (state_q == EX_BUSY) && done;
    end

    assert_start_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    assert_exec_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);
    assert_start_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go) |=> start);
endmodule

// File: rtl/flc_cs_ctrl.sv
module flc_cs_ctrl
    import flc_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_req,
    input  logic [DEV_W-1:0] sel_id,
    input  logic             rel_req,
    output logic [NUM_CS-1:0] cs_n
);
    cs_state_e        state_q, state_d;
    logic [DEV_W-1:0] id_q, id_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_OPEN;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    always_comb begin
        state_d = state_q;
        id_d    = id_q;
        unique case (state_q)
            CS_OPEN, CS_HELD: begin
                if (sel_req) begin
                    if (32'(sel_id) < NUM_CS) begin
                        state_d = CS_HELD;
                        id_d    = sel_id;
                    end else begin
                        state_d = CS_OPEN;
                    end
                end else if (rel_req) begin
                    state_d = CS_OPEN;
                end
            end
            default: state_d = CS_OPEN;
        endcase
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs_n[g] = !((state_q == CS_HELD) && (id_q == DEV_W'(g)));
    end

    assert_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && !sel_req) |=> (&cs_n));
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output logic                         reg_err,
    output logic                         eng_start,
    input  logic                         eng_done,
    input  logic                         eng_din_we,
    input  logic [1:0]                   eng_din_idx,
    input  logic [31:0]                  eng_din_data,
    output logic [31:0]                  cfg_read,
    output logic [31:0]                  cfg_write,
    output logic [31:0]                  cfg_cmd,
    output logic [31:0]                  cmd_word,
    output logic [31:0]                  addr_word,
    output logic [NUM_DATA*DATA_W-1:0]   dout_words,
    output logic [NUM_CS-1:0]            cs_n,
    output logic                         irq
);
    reg_sel_t sel;
    logic [DATA_W-1:0] rdcfg_q, wrcfg_q, cmdcfg_q, ctrl_q, cmd_q, addr_q, pcfg_q, gcfg_q;
    logic [DATA_W-1:0] dout_q [NUM_DATA];
    logic [DATA_W-1:0] din_q  [NUM_DATA];
    logic [DATA_W-1:0] pcmd_q [NUM_PCMD];
    logic              rdy_q, rdy_d;
    logic [DATA_W-1:0] rd_val, cmd_wval, rdata_q;
    logic              err_d, err_q;
    logic              ctrl_wr, swcs_flip, exec_pend;
    logic              sel_req, rel_req, go, busy, finish;

    flc_decode #(.ADDR_W(ADDR_W)) u_decode (.addr(reg_addr), .sel(sel));

    assign ctrl_wr   = reg_wr && (sel.kind == RK_CTRL);
    assign go        = ctrl_wr && reg_wdata[B_EXEC];

    flc_exec_fsm u_exec (
        .clk(clk), .rst_n(rst_n), .go(go), .done(eng_done),
        .start(eng_start), .busy(busy), .finish(finish)
    );

    // chip-select requests from a change of the software select bit
    assign swcs_flip = ctrl_wr && (reg_wdata[B_SWCS] != ctrl_q[B_SWCS]);
    assign exec_pend = busy || reg_wdata[B_EXEC];
    assign sel_req   = swcs_flip && !reg_wdata[B_SWCS];
    assign rel_req   = swcs_flip && reg_wdata[B_SWCS] && !exec_pend;

    flc_cs_ctrl #(.NUM_CS(NUM_CS)) u_cs (
        .clk(clk), .rst_n(rst_n), .sel_req(sel_req),
        .sel_id(reg_wdata[B_DEV +: DEV_W]), .rel_req(rel_req), .cs_n(cs_n)
    );

    // command setup write with partial field lock (R4)
    always_comb begin
        cmd_wval = reg_wdata;
        if (cmdcfg_q[B_FLOCK])
            cmd_wval = (reg_wdata & ~FIELD_LOCK_MASK) | (cmdcfg_q & FIELD_LOCK_MASK);
    end

    // ready flag: completion wins over a clearing write (R5)
    always_comb begin
        rdy_d = rdy_q;
        if (finish)                        rdy_d = 1'b1;
        else if (ctrl_wr && reg_wdata[B_RDY]) rdy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdcfg_q  <= '0;
            wrcfg_q  <= '0;
            cmdcfg_q <= RST_CMDCFG;
            ctrl_q   <= RST_CTRL;
            cmd_q    <= RST_CMD;
            addr_q   <= '0;
            pcfg_q   <= RST_PCFG;
            gcfg_q   <= RST_GCFG;
            rdy_q    <= 1'b0;
        end else begin
            rdy_q <= rdy_d;
            if (reg_wr) begin
                unique case (sel.kind)
                    RK_RDCFG:  if (!rdcfg_q[B_LOCK])  rdcfg_q  <= reg_wdata;
                    RK_WRCFG:  if (!wrcfg_q[B_LOCK])  wrcfg_q  <= reg_wdata;
                    RK_CMDCFG: if (!cmdcfg_q[B_LOCK]) cmdcfg_q <= cmd_wval;
                    RK_CTRL:   ctrl_q <= reg_wdata & ~CTRL_LIVE_MASK;
                    RK_CMD:    cmd_q  <= reg_wdata;
                    RK_ADDR:   addr_q <= reg_wdata;
                    RK_PCFG:   pcfg_q <= reg_wdata;
                    RK_GCFG:   gcfg_q <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_DATA; g++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dout_q[g] <= '0;
                din_q[g]  <= '0;
            end else begin
                if (reg_wr && sel.kind == RK_DOUT && sel.idx == IDX_W'(g))
                    dout_q[g] <= reg_wdata;
                if (eng_din_we && eng_din_idx == 2'(g))
                    din_q[g] <= eng_din_data;
            end
        end
        assign dout_words[g*DATA_W +: DATA_W] = dout_q[g];
    end

    for (genvar g = 0; g < NUM_PCMD; g++) begin : g_pcmd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pcmd_q[g] <= '0;
            else if (reg_wr && sel.kind == RK_PCMD && sel.idx == IDX_W'(g))
                pcmd_q[g] <= reg_wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        case (sel.kind)
            RK_RDCFG:  rd_val = rdcfg_q;
            RK_WRCFG:  rd_val = wrcfg_q;
            RK_CMDCFG: rd_val = cmdcfg_q;
            RK_CTRL:   rd_val = ctrl_q | {7'b0, rdy_q, 23'b0, busy};
            RK_CMD:    rd_val = cmd_q;
            RK_ADDR:   rd_val = addr_q;
            RK_PCFG:   rd_val = pcfg_q;
            RK_GCFG:   rd_val = gcfg_q;
            RK_DOUT:   for (int i = 0; i < NUM_DATA; i++) if (sel.idx == IDX_W'(i)) rd_val = dout_q[i];
            RK_DIN:    for (int i = 0; i < NUM_DATA; i++) if (sel.idx == IDX_W'(i)) rd_val = din_q[i];
            RK_PCMD:   for (int i = 0; i < NUM_PCMD; i++) if (sel.idx == IDX_W'(i)) rd_val = pcmd_q[i];
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        err_d = 1'b0;
        if (reg_wr) begin
            case (sel.kind)
                RK_NONE, RK_DIN: err_d = 1'b1;
                RK_RDCFG:        err_d = rdcfg_q[B_LOCK];
                RK_WRCFG:        err_d = wrcfg_q[B_LOCK];
                RK_CMDCFG:       err_d = cmdcfg_q[B_LOCK];
                default:         err_d = 1'b0;
            endcase
        end
        if (reg_rd && sel.kind == RK_NONE) err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= reg_rd ? rd_val : '0;
            err_q   <= err_d;
        end
    end

    assign reg_rdata = rdata_q;
    assign reg_err   = err_q;
    assign cfg_read  = rdcfg_q;
    assign cfg_write = wrcfg_q;
    assign cfg_cmd   = cmdcfg_q;
    assign cmd_word  = cmd_q;
    assign addr_word = addr_q;
    assign irq       = rdy_q & ctrl_q[B_IE];

    assert_rdcfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdcfg_q[B_LOCK] |=> $stable(rdcfg_q));
    assert_wrcfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrcfg_q[B_LOCK] |=> $stable(wrcfg_q));
    assert_cmdcfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmdcfg_q[B_LOCK] |=> $stable(cmdcfg_q));
    assert_fields_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmdcfg_q[B_FLOCK] |=> $stable(cmdcfg_q & FIELD_LOCK_MASK));
    assert_done_sets_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> rdy_q);
    assert_din_only_engine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_din_we |=> $stable(din_q[0]));
endmodule

// File: tb/test_flash_ctl_regs.sv
module test_flash_ctl_regs;
    localparam int NCS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err, eng_start, irq;
    logic        eng_done = 0, eng_din_we = 0;
    logic [1:0]  eng_din_idx = '0;
    logic [31:0] eng_din_data = '0;
    logic [31:0] cfg_read, cfg_write, cfg_cmd, cmd_word, addr_word;
    logic [127:0] dout_words;
    logic [NCS-1:0] cs_n;

    int tests = 0, fails = 0;
    bit finished = 0;

    logic [31:0] m [0:31];
    bit m_rdy, m_busy;
    int m_cs;

    always #5 clk = ~clk;

    flash_ctl_regs #(.ADDR_W(12), .NUM_CS(NCS)) i_flash_ctl_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .eng_start(eng_start), .eng_done(eng_done),
        .eng_din_we(eng_din_we), .eng_din_idx(eng_din_idx), .eng_din_data(eng_din_data),
        .cfg_read(cfg_read), .cfg_write(cfg_write), .cfg_cmd(cfg_cmd),
        .cmd_word(cmd_word), .addr_word(addr_word), .dout_words(dout_words),
        .cs_n(cs_n), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int i = 0; i < 32; i++) m[i] = '0;
        m[2] = 32'h400; m[3] = 32'h10000; m[4] = 32'hB; m[6] = 32'h400; m[30] = 32'hB;
        m_rdy = 0; m_busy = 0; m_cs = -1;
    endfunction

    function automatic bit mapped(input int w);
        return (w <= 6) || (w >= 8 && w <= 25) || (w == 30);
    endfunction

    function automatic bit mdl_write(input logic [11:0] a, input logic [31:0] v);
        int w = int'(a[11:2]);
        if (a[1:0] != 0 || !mapped(w)) return 1;
        if (w >= 12 && w <= 15) return 1;
        if (w <= 2 && m[w][31]) return 1;
        if (w == 2 && m[2][30]) m[2] = (v & ~32'h403) | (m[2] & 32'h403);
        else if (w == 3) begin
            if (v[16] != m[3][16]) begin
                if (!v[16]) m_cs = (int'(v[9:8]) < NCS) ? int'(v[9:8]) : -1;
                else if (!(m_busy || v[0])) m_cs = -1;
            end
            if (v[24]) m_rdy = 0;
            m[3] = v & ~32'h0100_0001;
            if (v[0]) m_busy = 1;
        end else m[w] = v;
        return 0;
    endfunction

    function automatic logic [31:0] mdl_read(input logic [11:0] a, output bit err);
        int w = int'(a[11:2]);
        err = 0;
        if (a[1:0] != 0 || !mapped(w)) begin err = 1; return 0; end
        if (w == 3) return m[3] | {7'b0, m_rdy, 23'b0, m_busy};
        return m[w];
    endfunction

    task automatic chk_outs(input string req);
        logic [NCS-1:0] e_cs = '1;
        if (m_cs >= 0) e_cs[m_cs] = 1'b0;
        chk({req, " cs_n"}, 32'(cs_n), 32'(e_cs));
        chk({req, " irq"}, 32'(irq), 32'(m_rdy & m[3][25]));
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] v, input string req);
        bit e = mdl_write(a, v);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
        chk({req, " err"}, 32'(reg_err), 32'(e));
        chk_outs(req);
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        bit e;
        logic [31:0] x = mdl_read(a, e);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
        chk({req, " data"}, reg_rdata, x);
        chk({req, " err"}, 32'(reg_err), 32'(e));
    endtask

    task automatic eng_load(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk); eng_din_we = 1; eng_din_idx = idx; eng_din_data = d;
        @(negedge clk); eng_din_we = 0;
        m[12 + int'(idx)] = d;
    endtask

    task automatic finish_exec();
        @(negedge clk); eng_done = 1;
        @(negedge clk); eng_done = 0;
        m_busy = 0; m_rdy = 1;
        chk_outs("R5 after done");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 reset state
        for (int w = 0; w < 32; w++) do_read(12'(w * 4), "R2 reset word");
        chk_outs("R2 reset");
        chk("R2 start idle", 32'(eng_start), 0);

        // R1 plain words and outputs
        do_write(12'h010, 32'hA5A5_0103, "R1 opcode");
        do_write(12'h014, 32'h0012_3456, "R1 address");
        do_write(12'h024, 32'hDEAD_BEEF, "R1 dout1");
        do_write(12'h064, 32'h1357_9BDF, "R1 pcmd9");
        do_write(12'h078, 32'h0000_00F0, "R1 gcfg");
        do_read(12'h024, "R1 dout1");
        do_read(12'h064, "R1 pcmd9");
        do_read(12'h078, "R1 gcfg");
        chk("R1 cmd_word", cmd_word, 32'hA5A5_0103);
        chk("R1 addr_word", addr_word, 32'h0012_3456);
        chk("R1 dout_words", dout_words[63:32], 32'hDEAD_BEEF);

        // R9 incoming data
        eng_load(2'd2, 32'hCAFE_F00D);
        do_read(12'h038, "R9 din2 load");
        do_write(12'h038, 32'h1111_1111, "R9 din2 sw write");
        do_read(12'h038, "R9 din2 kept");

        // R10 unmapped / misaligned
        do_read(12'h01C, "R10 hole read");
        do_read(12'h06C, "R10 past pcmd read");
        do_write(12'h015, 32'hFFFF_FFFF, "R10 misaligned write");
        do_read(12'h014, "R10 address kept");
        do_read(12'h016, "R10 misaligned read");

        // R4 field lock
        do_write(12'h008, 32'h4000_0401, "R4 set field lock");
        do_write(12'h008, 32'h0000_0002, "R4 locked write");
        do_read(12'h008, "R4 fields kept");
        chk("R4 cfg_cmd", cfg_cmd, 32'h0000_0401);
        do_write(12'h008, 32'h0000_0002, "R4 unlocked write");
        do_read(12'h008, "R4 fields free");

        // R6 / R5 / R11 execution and ready
        do_write(12'h00C, 32'h0201_0001, "R6 launch");
        chk("R6 start pulse", 32'(eng_start), 1);
        @(negedge clk);
        chk("R6 start single", 32'(eng_start), 0);
        do_read(12'h00C, "R6 exec set");
        do_write(12'h00C, 32'h0201_0000, "R6 sw clear attempt");
        do_read(12'h00C, "R6 exec kept");
        do_write(12'h00C, 32'h0201_0001, "R6 relaunch while busy");
        chk("R6 no restart", 32'(eng_start), 0);
        finish_exec();
        do_read(12'h00C, "R5 ready set");
        chk("R11 irq high", 32'(irq), 1);
        do_write(12'h00C, 32'h0201_0000, "R5 write zero");
        do_read(12'h00C, "R5 ready kept");
        do_write(12'h00C, 32'h0301_0000, "R5 write one");
        do_read(12'h00C, "R5 ready cleared");
        chk("R11 irq low", 32'(irq), 0);

        // R7 / R8 chip select
        do_write(12'h00C, 32'h0000_0100, "R7 select dev1");
        do_write(12'h00C, 32'h0001_0001, "R8 rise with exec write");
        finish_exec();
        do_write(12'h00C, 32'h0000_0200, "R7 select dev2");
        do_write(12'h00C, 32'h0000_0201, "R8 launch held");
        do_write(12'h00C, 32'h0001_0000, "R8 rise while busy");
        finish_exec();
        do_write(12'h00C, 32'h0000_0300, "R7 out of range dev3");
        do_write(12'h00C, 32'h0001_0000, "R8 rise none held");
        do_write(12'h00C, 32'h0000_0000, "R7 select dev0");
        do_write(12'h00C, 32'h0001_0000, "R8 release");

        // random mix (R1, R4, R5, R7, R8, R9, R10, R11)
        for (int it = 0; it < 400; it++) begin
            int w = $urandom_range(0, 31);
            logic [11:0] a = 12'(w * 4);
            logic [31:0] v = $urandom;
            if (w <= 2) v[31] = 1'b0;
            if (w == 3) v[0] = 1'b0;
            if ($urandom_range(0, 15) == 0) a = a | 12'($urandom_range(1, 3));
            if ($urandom_range(0, 7) == 0) eng_load(2'($urandom_range(0, 3)), $urandom);
            do_write(a, v, "R1 random write");
            do_read(12'($urandom_range(0, 31) * 4), "R1 random read");
        end

        // R3 self locks
        do_write(12'h000, 32'h8000_1234, "R3 lock read setup");
        do_write(12'h000, 32'h0000_0000, "R3 read setup locked");
        do_read(12'h000, "R3 read setup kept");
        do_write(12'h004, 32'h8000_00AA, "R3 lock write setup");
        do_write(12'h004, 32'h0000_0055, "R3 write setup locked");
        do_read(12'h004, "R3 write setup kept");
        chk("R3 cfg_write", cfg_write, 32'h8000_00AA);
        do_write(12'h008, 32'h8000_0400, "R3 lock command setup");
        do_write(12'h008, 32'h0000_0001, "R3 command setup locked");
        do_read(12'h008, "R3 command setup kept");
        chk("R3 cfg_read", cfg_read, 32'h8000_1234);

        summary();
    end
endmodule